// File: doc/BRIEF.md
# Guarded Single-Clock FIFO Buffer

This block is a first-in-first-out word buffer on one clock. A producer with hard timing, such as a sampler, pushes words into it without waiting, and a slower consumer drains them in bursts when it has time. The word width, the depth (a power of two) and the two early-warning thresholds are parameters.

Reads are in normal mode: the output word is a register that loads the oldest stored word only on a clock edge where a read is accepted, and it keeps the last word read at all other times. The occupancy bus is only log2(depth) bits wide. With the buffer completely full it reads zero and the full flag acts as its missing top bit. Requests that would overflow or underflow the buffer are dropped inside the block. When a read and a write arrive together, both are judged against the state before the edge. On a full buffer the read wins. On an empty buffer the write wins. A synchronous clear empties the buffer and beats any write in the same cycle. An asynchronous active-low clear forces the reset state at once.

Top module: `sync_fifo_guarded`

## Requirements
- R1: While `async_clr_n` is low, the outputs take their reset values at once and hold them: `level` 0, `empty` 1, `full` 0, `almost_empty` 1 (default thresholds), `almost_full` 0 and `rd_data` all zeros.
- R2: Words leave in the order they were written. `rd_data` changes only on an edge where a read is accepted. It then shows the oldest stored word and holds that value until the next accepted read.
- R3: `level` is log2(DEPTH) bits wide and equals the stored count modulo DEPTH. With DEPTH words stored, `level` is 0 and `full` is 1. `empty` and `full` are never high together.
- R4: A write request on a full buffer with no read request is discarded. The stored words, `level` and the flags stay unchanged.
- R5: A read request on an empty buffer with no write request is ignored. `rd_data` keeps the last word read and `level` stays 0.
- R6: A read and a write requested together on a full buffer perform the read and drop the write. The buffer is left holding DEPTH-1 words and `full` falls to 0.
- R7: A read and a write requested together on an empty buffer perform the write and ignore the read. The buffer is left holding one word and `rd_data` is unchanged.
- R8: A read and a write requested together on a buffer that is neither empty nor full perform both operations and leave `level` unchanged.
- R9: `sync_clr` high at an edge empties the buffer on that edge (`level` 0, `empty` 1, `full` 0). A write requested in the same cycle is lost.
- R10: `almost_empty` is 1 when the true occupancy is below AE_TH. `almost_full` is 1 when the true occupancy is at or above AF_TH. Both flags are registered and change on the same edge as `level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| async_clr_n | input | 1 | Asynchronous clear, active low |
| sync_clr | input | 1 | Synchronous clear, active high; takes priority over both requests |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_req | input | 1 | Read request |
| rd_data | output | WIDTH | Registered output word; holds the last word read |
| level | output | log2(DEPTH) | Stored word count modulo DEPTH |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored; top bit of the occupancy |
| almost_empty | output | 1 | Occupancy below AE_TH |
| almost_full | output | 1 | Occupancy at or above AF_TH |

## Verification
On every cycle the assertions check the occupancy outcome of each guarded case: a dropped write on full, a combined request on a full, an empty or a partly filled buffer, and a synchronous clear. They also check that the output word holds unless a read is accepted, that the almost flags match the registered occupancy, and that `full` coincides with an occupancy of DEPTH. Only the bench scenarios can show that words come out in write order with the right values, and that the word offered with a dropped or cleared write never appears later. The scenarios also show that the asynchronous clear acts between clock edges and that `level` wraps to zero at full.

// File: rtl/fifo_pkg.sv
// Shared types for the guarded FIFO.
// Assumes nothing beyond the standard language.
package fifo_pkg;
    // Resolved per-cycle action after the overflow and underflow guards
    typedef struct packed {
        logic clr;    // synchronous clear wins this cycle
        logic wr_ok;  // write accepted
        logic rd_ok;  // read accepted
    } fifo_op_t;
endpackage

// File: rtl/fifo_ctrl.sv
// Pointer and occupancy control for the guarded FIFO.
// Resolves requests against the registered flags of the previous state:
// a write on full is dropped, a read on empty is ignored, and sync clear
// overrides both. Assumes DEPTH is a power of two so the pointers wrap.
module fifo_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          async_clr_n,
    input  logic          sync_clr,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          empty_q,
    input  logic          full_q,
    output fifo_op_t      op,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] occ_q,
    output logic [CW-1:0] occ_nx
);

    // Guard the requests and compute the next occupancy
    always_comb begin
        op.clr   = sync_clr;
        op.wr_ok = wr_req && !full_q && !sync_clr;
        op.rd_ok = rd_req && !empty_q && !sync_clr;
        if (op.clr)
            occ_nx = '0;
        else if (op.wr_ok && !op.rd_ok)
            occ_nx = occ_q + CW'(1);
        else if (op.rd_ok && !op.wr_ok)
            occ_nx = occ_q - CW'(1);
        else
            occ_nx = occ_q;
    end

    // Advance pointers and occupancy; async clear returns to reset state
    always_ff @(posedge clk or negedge async_clr_n) begin
        if (!async_clr_n) begin
            wptr  <= '0;
            rptr  <= '0;
            occ_q <= '0;
        end else begin
            occ_q <= occ_nx;
            if (op.clr) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (op.wr_ok) wptr <= wptr + AW'(1);
                if (op.rd_ok) rptr <= rptr + AW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!async_clr_n)
        full_q && wr_req && !rd_req && !sync_clr |=> occ_q == CW'(DEPTH)); // R4
    AST_FULL_RDWR: assert property (@(posedge clk) disable iff (!async_clr_n)
        full_q && wr_req && rd_req && !sync_clr |=> occ_q == CW'(DEPTH - 1)); // R6
    AST_EMPTY_RDWR: assert property (@(posedge clk) disable iff (!async_clr_n)
        empty_q && wr_req && rd_req && !sync_clr |=> occ_q == CW'(1)); // R7
    AST_PARTIAL_RDWR: assert property (@(posedge clk) disable iff (!async_clr_n)
        !empty_q && !full_q && wr_req && rd_req && !sync_clr |=> $stable(occ_q)); // R8
    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!async_clr_n)
        sync_clr |=> occ_q == '0 && empty_q && !full_q); // R9

endmodule

// File: rtl/fifo_store.sv
// Word storage and registered output for the guarded FIFO.
// Writes and reads act only on accepted operations from the controller;
// the output register holds the last word read and is zeroed only by the
// asynchronous clear. Storage itself has no reset.
module fifo_store
    import fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             async_clr_n,
    input  fifo_op_t         op,
    input  logic [AW-1:0]    wptr,
    input  logic [AW-1:0]    rptr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store an accepted write word
    always_ff @(posedge clk) begin
        if (op.wr_ok) mem[wptr] <= wr_data;
    end

    // Load the output word on an accepted read only
    always_ff @(posedge clk or negedge async_clr_n) begin
        if (!async_clr_n)
            rd_data <= '0;
        else if (op.rd_ok)
            rd_data <= mem[rptr];
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!async_clr_n)
        !op.rd_ok |=> $stable(rd_data)); // R2

endmodule

// File: rtl/fifo_flags.sv
// Registered status flags for the guarded FIFO.
// All flags are taken from the next occupancy (full count including the
// top bit), so they change on the same edge as the count.
module fifo_flags #(
    parameter int DEPTH = 8,
    parameter int AE_TH = 2,
    parameter int AF_TH = 6,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          async_clr_n,
    input  logic [CW-1:0] occ_nx,
    input  logic [CW-1:0] occ_q,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);

    // Register the four flags from the next occupancy
    always_ff @(posedge clk or negedge async_clr_n) begin
        if (!async_clr_n) begin
            empty        <= 1'b1;
            full         <= 1'b0;
            almost_empty <= (AE_TH > 0);
            almost_full  <= (AF_TH <= 0);
        end else begin
            empty        <= (occ_nx == '0);
            full         <= (occ_nx == CW'(DEPTH));
            almost_empty <= (int'(occ_nx) < AE_TH);
            almost_full  <= (int'(occ_nx) >= AF_TH);
        end
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!async_clr_n)
        !(empty && full)); // R3
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!async_clr_n)
        full == (occ_q == CW'(DEPTH))); // R3
    AST_ALMOST_EMPTY: assert property (@(posedge clk) disable iff (!async_clr_n)
        almost_empty == (int'(occ_q) < AE_TH)); // R10
    AST_ALMOST_FULL: assert property (@(posedge clk) disable iff (!async_clr_n)
        almost_full == (int'(occ_q) >= AF_TH)); // R10

endmodule

// File: rtl/sync_fifo_guarded.sv
// Single-clock FIFO with built-in overflow and underflow guards.
// Normal (registered) read mode; the count bus is log2(DEPTH) bits and
// wraps to zero at full, with the full flag as its top bit.
// Assumes DEPTH is a power of two and all inputs are synchronous to clk
// except async_clr_n.
module sync_fifo_guarded
    import fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int AE_TH = 2,
    parameter int AF_TH = 6,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             async_clr_n,
    input  logic             sync_clr,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic [AW-1:0]    level,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);

    fifo_op_t      op;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] occ_q;
    logic [CW-1:0] occ_nx;

    fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .async_clr_n(async_clr_n), .sync_clr(sync_clr),
        .wr_req(wr_req), .rd_req(rd_req), .empty_q(empty), .full_q(full),
        .op(op), .wptr(wptr), .rptr(rptr), .occ_q(occ_q), .occ_nx(occ_nx)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .async_clr_n(async_clr_n), .op(op),
        .wptr(wptr), .rptr(rptr), .wr_data(wr_data), .rd_data(rd_data)
    );

    fifo_flags #(.DEPTH(DEPTH), .AE_TH(AE_TH), .AF_TH(AF_TH)) u_flags (
        .clk(clk), .async_clr_n(async_clr_n), .occ_nx(occ_nx), .occ_q(occ_q),
        .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // Expose the count without its top bit
    assign level = occ_q[AW-1:0];

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!async_clr_n)
        empty && rd_req && !wr_req && !sync_clr |=> empty && $stable(rd_data)); // R5
    AST_EMPTY_RD_HOLD: assert property (@(posedge clk) disable iff (!async_clr_n)
        empty && rd_req && wr_req && !sync_clr |=> $stable(rd_data)); // R7

endmodule

// File: tb/sim_sync_fifo_guarded.sv
// Directed bench for the guarded FIFO: one task per scenario.
module sim_sync_fifo_guarded;
    localparam int WIDTH = 8;
    localparam int DEPTH = 8;
    localparam int AE_TH = 2;
    localparam int AF_TH = 6;
    localparam int AW = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             async_clr_n = 1'b0;
    logic             sync_clr = 1'b0;
    logic             wr_req = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_req = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic [AW-1:0]    level;
    logic             empty, full, almost_empty, almost_full;

    int checks = 0;
    int fails = 0;
    int model[$];
    int exp_out = 0;

    always #4 clk = ~clk;

    sync_fifo_guarded #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_TH(AE_TH), .AF_TH(AF_TH)) u0 (
        .clk(clk), .async_clr_n(async_clr_n), .sync_clr(sync_clr),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .level(level), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every output with the behavioural model
    task automatic chk_all(input string tag);
        int n = model.size();
        chk({tag, " level"}, int'(level), n % DEPTH);
        chk({tag, " empty"}, int'(empty), int'(n == 0));
        chk({tag, " full"}, int'(full), int'(n == DEPTH));
        chk({tag, " R10 almost_empty"}, int'(almost_empty), int'(n < AE_TH));
        chk({tag, " R10 almost_full"}, int'(almost_full), int'(n >= AF_TH));
        chk({tag, " R2 rd_data"}, int'(rd_data), exp_out);
    endtask

    // One clock: drive at falling edge, update model, sample at next falling edge
    task automatic step(input logic w, input logic r, input int d, input logic c);
        int n = model.size();
        wr_req = w; rd_req = r; wr_data = WIDTH'(d); sync_clr = c;
        if (c) model.delete();
        else begin
            if (r && n > 0) exp_out = model.pop_front();
            if (w && n < DEPTH) model.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; sync_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 level", int'(level), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_fill_and_wrap();
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 8'h10 + i, 1'b0);
            chk_all("R10 fill");
        end
        chk("R3 level wraps at full", int'(level), 0);
        chk("R3 full at depth", int'(full), 1);
    endtask

    task automatic t_overflow();
        step(1'b1, 1'b0, 8'hEE, 1'b0);
        chk("R4 full held", int'(full), 1);
        chk("R4 level held", int'(level), 0);
        chk("R4 rd_data unchanged", int'(rd_data), 0);
    endtask

    task automatic t_drain_order();
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 0, 1'b0);
            chk("R2 order", int'(rd_data), 8'h10 + i);
            chk_all("R2 drain");
            step(1'b0, 1'b0, 0, 1'b0);
            chk("R2 hold between reads", int'(rd_data), 8'h10 + i);
        end
    endtask

    task automatic t_underflow();
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R5 rd_data holds", int'(rd_data), 8'h17);
        chk("R5 level zero", int'(level), 0);
        chk("R5 empty", int'(empty), 1);
    endtask

    task automatic t_rdwr_empty();
        step(1'b1, 1'b1, 8'h5A, 1'b0);
        chk("R7 level one", int'(level), 1);
        chk("R7 rd_data holds", int'(rd_data), 8'h17);
        chk_all("R7 empty rdwr");
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R7 written word read", int'(rd_data), 8'h5A);
    endtask

    task automatic t_rdwr_partial();
        step(1'b1, 1'b0, 8'h21, 1'b0);
        step(1'b1, 1'b0, 8'h22, 1'b0);
        step(1'b1, 1'b1, 8'h23, 1'b0);
        chk("R8 level unchanged", int'(level), 2);
        chk("R8 read performed", int'(rd_data), 8'h21);
        chk_all("R8 partial rdwr");
        step(1'b0, 1'b1, 0, 1'b0);
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R8 written word kept", int'(rd_data), 8'h23);
    endtask

    task automatic t_rdwr_full();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 8'h40 + i, 1'b0);
        step(1'b1, 1'b1, 8'hDD, 1'b0);
        chk("R6 level depth-1", int'(level), DEPTH - 1);
        chk("R6 full drops", int'(full), 0);
        chk("R6 read performed", int'(rd_data), 8'h40);
        chk_all("R6 full rdwr");
        for (int i = 1; i < DEPTH; i++) step(1'b0, 1'b1, 0, 1'b0);
        chk("R6 dropped word absent", int'(rd_data), 8'h47);
        chk("R6 drained", int'(empty), 1);
    endtask

    task automatic t_sync_clear();
        step(1'b1, 1'b0, 8'h61, 1'b0);
        step(1'b1, 1'b0, 8'h62, 1'b0);
        step(1'b1, 1'b0, 8'h63, 1'b0);
        step(1'b1, 1'b0, 8'h64, 1'b1);
        chk("R9 level", int'(level), 0);
        chk("R9 empty", int'(empty), 1);
        chk("R9 full", int'(full), 0);
        step(1'b1, 1'b0, 8'h70, 1'b0);
        step(1'b0, 1'b1, 0, 1'b0);
        chk("R9 write lost, next word first", int'(rd_data), 8'h70);
        chk("R9 empty again", int'(empty), 1);
    endtask

    task automatic t_async_clear();
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'h80 + i, 1'b0);
        step(1'b0, 1'b1, 0, 1'b0);
        #1;
        async_clr_n = 1'b0;
        #1;
        model.delete();
        exp_out = 0;
        chk("R1 async level", int'(level), 0);
        chk("R1 async empty", int'(empty), 1);
        chk("R1 async almost_full", int'(almost_full), 0);
        chk("R1 async rd_data", int'(rd_data), 0);
        @(negedge clk);
        async_clr_n = 1'b1;
        chk_all("R1 after async clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        async_clr_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fill_and_wrap();
        t_overflow();
        t_drain_order();
        t_underflow();
        t_rdwr_empty();
        t_rdwr_partial();
        t_rdwr_full();
        t_sync_clear();
        t_async_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule